// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a bus-mapped watchdog. A counter advances on pulses of a slow watchdog tick, optionally divided by 256, and when it reaches the programmed timeout the block raises a timeout flag and pulses a reset request. Software keeps the system alive by writing a refresh key to the counter register before the timeout expires.

Configuration is guarded by keys. Before the control/status or timeout registers will accept a write, software must write an unlock key to the counter register. In 32-bit command mode the key is one word. With that mode off, the key is two consecutive half-words. An accepted unlock opens a short window. The window ends on the first control/status write or after a fixed number of bus cycles. While the watchdog is enabled, a wrong key or a write to the guarded registers outside the window is treated as a fault and causes an immediate reset request.

The key checker is a four-state machine: `K_LOCKED` (idle), `K_UNL_HALF` (first unlock half-word seen), `K_REF_HALF` (first refresh half-word seen) and `K_OPEN` (unlock window). The transitions are as follows:
- `K_LOCKED`/`K_OPEN` to `K_OPEN` on a one-word unlock key.
- `K_LOCKED`/`K_OPEN` to `K_UNL_HALF` or `K_REF_HALF` on a first half-word.
- `K_UNL_HALF` to `K_OPEN` on the matching second half.
- `K_REF_HALF` to `K_LOCKED` on any second write. The write refreshes the count if it matches and is a fault otherwise.
- `K_OPEN` to `K_LOCKED` on a control/status write, on window expiry, or on a bad key.
- Any wrong counter write returns the machine to `K_LOCKED`.

A one-word refresh keeps the current state.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the control/status register (offset 0x0) reads 0x00000420. That value has only update-allowed (bit 5) and reconfiguration-complete (bit 10) set. The timeout register (offset 0x8) reads TOVAL_RST (default 1024), the counter register (offset 0x4) reads 0, and rst_req is low.
- R2: Unlocking sets bit 11 (unlocked) and clears bit 10.
  - With bit 13 set (32-bit command mode), one counter write of 0xD928C520 unlocks the block.
  - With bit 13 clear, two consecutive counter writes are needed: 0x0000C520, then 0x0000D928. Any other second write leaves the block locked.
- R3: Writes to the control/status and timeout registers change configuration only while bit 11 reads 1. Otherwise they are ignored.
- R4: The unlock window closes on the first control/status write or after UNLOCK_WIN bus cycles (default 256). Bit 11 then reads 0, and bit 10 reads 1 from the cycle after the window closes.
- R5: A refresh returns the counter and the prescaler to 0. In 32-bit command mode the refresh key is one write of 0xB480A602. With that mode off, it is 0x0000A602 followed by 0x0000B480.
- R6: While enable (bit 7) is 1, each effective tick adds one to the counter. The tick on which the count would reach the timeout value has three effects: it sets the flag (bit 14), it pulses rst_req for exactly one cycle, and it returns the counter to 0. With enable at 0 the counter stays at 0.
- R7: With prescaler enable (bit 12) set, the counter advances once per 256 wd_tick pulses.
- R8: While enabled, each of the following raises rst_req in the next cycle:
  - a counter write that is neither a valid key nor the expected second half;
  - a control/status or timeout write made while locked.
  While disabled, these writes cause no reset request.
- R9: While update-allowed (bit 5) is 0, unlock keys are rejected and bit 11 stays 0.
- R10: Bits 11 and 10 ignore written values. Writing 1 to bit 14 clears the flag. Bits 13, 12, 9:8, 7, 5, 1 and 0 read back the last value accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits 1:0 must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| wd_tick | input | 1 | One-cycle pulse per watchdog clock period, synchronous to clk |
| rst_req | output | 1 | Reset request pulse |

## Verification
The assertions assume that wd_tick is a single-cycle pulse already synchronous to clk. They also assume that a bus access lasts exactly one cycle, so that two consecutive key half-words arrive as two separate write cycles. The stimulus follows both rules: every access is one strobed cycle driven on the falling edge, ticks are spaced at least two cycles apart, and reads never disturb the key machine. The prescaler test starts from a refresh, so that the divider phase is known.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    typedef enum logic [1:0] {
        K_LOCKED   = 2'd0,
        K_UNL_HALF = 2'd1,
        K_REF_HALF = 2'd2,
        K_OPEN     = 2'd3
    } key_st_t;

    localparam logic [31:0] KEY_UNLOCK  = 32'hD928_C520;
    localparam logic [31:0] KEY_REFRESH = 32'hB480_A602;
    localparam logic [15:0] UNL_LO = 16'hC520;
    localparam logic [15:0] UNL_HI = 16'hD928;
    localparam logic [15:0] REF_LO = 16'hA602;
    localparam logic [15:0] REF_HI = 16'hB480;

    localparam logic [1:0] REG_CS  = 2'd0;
    localparam logic [1:0] REG_CNT = 2'd1;
    localparam logic [1:0] REG_TOV = 2'd2;

    localparam int B_FLAG  = 14;
    localparam int B_CMD32 = 13;
    localparam int B_PRES  = 12;
    localparam int B_EN    = 7;
    localparam int B_UPD   = 5;
endpackage

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
    import wdk_pkg::*;
#(
    parameter int WIN = 256
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cnt_wr,
    input  logic [31:0] wdata,
    input  logic        cs_wr,
    input  logic        cmd32,
    input  logic        upd_ok,
    output logic        unlock_ok,
    output logic        refresh_ok,
    output logic        bad_key,
    output logic        open_o,
    output logic        close_o
);
    localparam int WIN_W = (WIN > 2) ? $clog2(WIN) : 1;

    key_st_t          st_q, st_d;
    logic [WIN_W-1:0] win_q;
    logic             win_done;
    logic             lo16, is_unl32, is_ref32, is_unl_lo, is_unl_hi, is_ref_lo, is_ref_hi;
    logic             idle_like, half_ok;

    assign lo16      = (wdata[31:16] == 16'h0);
    assign is_unl32  = (wdata == KEY_UNLOCK);
    assign is_ref32  = (wdata == KEY_REFRESH);
    assign is_unl_lo = lo16 && (wdata[15:0] == UNL_LO);
    assign is_unl_hi = lo16 && (wdata[15:0] == UNL_HI);
    assign is_ref_lo = lo16 && (wdata[15:0] == REF_LO);
    assign is_ref_hi = lo16 && (wdata[15:0] == REF_HI);
    assign win_done  = (win_q == WIN_W'(WIN - 1));
    assign idle_like = (st_q == K_LOCKED) || (st_q == K_OPEN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= K_LOCKED;
        end else begin
            st_q <= st_d;
        end
    end

    // window timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (unlock_ok) begin
            win_q <= '0;
        end else if (st_q == K_OPEN && !win_done) begin
            win_q <= win_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            K_LOCKED, K_OPEN: begin
                if (cnt_wr) begin
                    if (cmd32) begin
                        if (is_unl32 && upd_ok) st_d = K_OPEN;
                        else if (is_ref32)      st_d = st_q;
                        else                    st_d = K_LOCKED;
                    end else begin
                        if (is_unl_lo && upd_ok) st_d = K_UNL_HALF;
                        else if (is_ref_lo)      st_d = K_REF_HALF;
                        else                     st_d = K_LOCKED;
                    end
                end else if (st_q == K_OPEN && (cs_wr || win_done)) begin
                    st_d = K_LOCKED;
                end
            end
            K_UNL_HALF: if (cnt_wr) st_d = is_unl_hi ? K_OPEN : K_LOCKED;
            K_REF_HALF: if (cnt_wr) st_d = K_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        half_ok    = idle_like && !cmd32 && ((is_unl_lo && upd_ok) || is_ref_lo);
        unlock_ok  = cnt_wr && ((idle_like && cmd32 && is_unl32 && upd_ok) ||
                                (st_q == K_UNL_HALF && is_unl_hi));
        refresh_ok = cnt_wr && ((idle_like && cmd32 && is_ref32) ||
                                (st_q == K_REF_HALF && is_ref_hi));
        bad_key    = cnt_wr && !unlock_ok && !refresh_ok && !half_ok;
        open_o     = (st_q == K_OPEN);
        close_o    = (st_q == K_OPEN) && (st_d != K_OPEN);
    end
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             pres,
    input  logic             clr,
    input  logic [CNT_W-1:0] toval,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   inc;
    logic             step;

    assign step = en && tick && (!pres || (&pre_q));
    assign inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign fire = step && !clr && (inc >= {1'b0, toval});
    assign cnt  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (!en || clr) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else begin
            if (!pres)      pre_q <= '0;
            else if (tick)  pre_q <= pre_q + 1'b1;
            if (fire)       cnt_q <= '0;
            else if (step)  cnt_q <= inc[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int          UNLOCK_WIN = 256,
    parameter int          PRE_W      = 8,
    parameter logic [31:0] TOVAL_RST  = 32'd1024
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        wd_tick,
    output logic        rst_req
);
    localparam int CNT_W = 32;

    logic [1:0]       word;
    logic             aligned, wr_any, cs_wr, cnt_wr, tv_wr;
    logic             flag, cmd32, pres, en, upd, run_wait, run_stop, rcs, close_q, rst_req_q;
    logic [1:0]       clks;
    logic [CNT_W-1:0] toval, cnt_val;
    logic             unlock_ok, refresh_ok, bad_key, ulk, closing, fire, violation;
    logic [31:0]      cs_img;

    assign word    = bus_addr[3:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_any  = bus_sel && bus_wr && aligned;
    assign cs_wr   = wr_any && (word == REG_CS);
    assign cnt_wr  = wr_any && (word == REG_CNT);
    assign tv_wr   = wr_any && (word == REG_TOV);

    wdk_keyfsm #(.WIN(UNLOCK_WIN)) u_key (
        .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(bus_wdata),
        .cs_wr(cs_wr), .cmd32(cmd32), .upd_ok(upd),
        .unlock_ok(unlock_ok), .refresh_ok(refresh_ok), .bad_key(bad_key),
        .open_o(ulk), .close_o(closing)
    );

    wdk_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(wd_tick), .en(en), .pres(pres),
        .clr(refresh_ok), .toval(toval), .cnt(cnt_val), .fire(fire)
    );

    assign violation = en && (bad_key || ((cs_wr || tv_wr) && !ulk));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag      <= 1'b0;
            cmd32     <= 1'b0;
            pres      <= 1'b0;
            clks      <= 2'b00;
            en        <= 1'b0;
            upd       <= 1'b1;
            run_wait  <= 1'b0;
            run_stop  <= 1'b0;
            toval     <= TOVAL_RST;
            rcs       <= 1'b1;
            close_q   <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            if (fire)                            flag <= 1'b1;
            else if (cs_wr && bus_wdata[B_FLAG]) flag <= 1'b0;
            if (cs_wr && ulk) begin
                cmd32    <= bus_wdata[B_CMD32];
                pres     <= bus_wdata[B_PRES];
                clks     <= bus_wdata[9:8];
                en       <= bus_wdata[B_EN];
                upd      <= bus_wdata[B_UPD];
                run_wait <= bus_wdata[1];
                run_stop <= bus_wdata[0];
            end
            if (tv_wr && ulk) toval <= bus_wdata;
            close_q <= closing;
            if (unlock_ok)    rcs <= 1'b0;
            else if (close_q) rcs <= 1'b1;
            rst_req_q <= violation || fire;
        end
    end

    assign cs_img  = {17'b0, flag, cmd32, pres, ulk, rcs, clks, en, 1'b0, upd,
                      3'b000, run_wait, run_stop};
    assign rst_req = rst_req_q;

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            case (word)
                REG_CS:  bus_rdata = cs_img;
                REG_CNT: bus_rdata = cnt_val;
                REG_TOV: bus_rdata = toval;
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdk_chk.sv
module wdk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ulk,
    input logic        rcs,
    input logic        cs_wr,
    input logic        tv_wr,
    input logic [31:0] toval,
    input logic        flag,
    input logic        rst_req,
    input logic        en,
    input logic        upd
);
    // R3
    locked_tov_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tv_wr && !ulk) |=> $stable(toval));
    // R4
    cfg_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ulk && cs_wr) |=> !ulk);
    // R4
    open_rcs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ulk |-> !rcs);
    // R6
    flag_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> rst_req);
    // R8
    rst_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(en));
    // R9
    upd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ulk) |-> $past(upd));
endmodule

bind wdog_keyed wdk_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ulk(ulk), .rcs(rcs), .cs_wr(cs_wr), .tv_wr(tv_wr),
    .toval(toval), .flag(flag), .rst_req(rst_req_q), .en(en), .upd(upd)
);

// File: tb/tb_wdog_keyed.sv
`timescale 1ns/1ps
module tb_wdog_keyed;
    logic        clk = 1'b0, rst_n = 1'b0, sel = 1'b0, wr = 1'b0, tick = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0, rdata, r;
    logic        rst_req;
    int n_chk = 0, n_fail = 0, rst_seen = 0, rst_mark = 0;

    always #4 clk = ~clk;

    wdog_keyed dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .wd_tick(tick), .rst_req(rst_req)
    );

    always @(negedge clk) if (rst_req) rst_seen++;

    typedef struct packed {
        logic        rd;
        logic [3:0]  a;
        logic [31:0] d;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VT [NV] = '{
        '{1'b1, 4'h0, 32'h0000_0420, 8'd1},   // R1 reset CS
        '{1'b1, 4'h8, 32'h0000_0400, 8'd1},   // R1 reset timeout
        '{1'b1, 4'h4, 32'h0000_0000, 8'd1},   // R1 reset counter
        '{1'b0, 4'h8, 32'h0000_0005, 8'd3},   // R3 locked write
        '{1'b1, 4'h8, 32'h0000_0400, 8'd3},   // R3 ignored
        '{1'b0, 4'h4, 32'h0000_C520, 8'd2},   // R2 first half
        '{1'b0, 4'h4, 32'h0000_D928, 8'd2},   // R2 second half
        '{1'b1, 4'h0, 32'h0000_0820, 8'd2},   // R2 unlocked, rcs low
        '{1'b0, 4'h8, 32'h0000_0003, 8'd3},   // R3 open write
        '{1'b1, 4'h8, 32'h0000_0003, 8'd3},
        '{1'b0, 4'h0, 32'h0000_2CA0, 8'd10},  // R10 status bits written 1
        '{1'b1, 4'h0, 32'h0000_24A0, 8'd10},  // R10/R4 closed, rcs set
        '{1'b0, 4'h4, 32'hB480_A602, 8'd5},   // R5 refresh
        '{1'b1, 4'h4, 32'h0000_0000, 8'd5}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
    endtask

    task automatic do_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); sel = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk); #1; d = rdata; sel = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic rst_delta(input string tag, input int exp);
        #1;
        chk(tag, 32'(rst_seen - rst_mark), 32'(exp));
        rst_mark = rst_seen;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        rst_mark = rst_seen;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset();
        chk("R1 rst_req low", 32'(rst_req), 32'd0);
        for (int i = 0; i < NV; i++) begin
            if (VT[i].rd) begin
                do_rd(VT[i].a, r);
                chk($sformatf("R%0d table %0d", VT[i].req, i), r, VT[i].d);
            end else begin
                do_wr(VT[i].a, VT[i].d);
            end
        end
        rst_delta("R8 none in table", 0);

        // R6 timeout with toval 3, 32-bit mode, enabled
        ticks(2);
        do_rd(4'h4, r); chk("R6 count 2", r, 32'd2);
        rst_delta("R6 before timeout", 0);
        ticks(1);
        rst_delta("R6 one pulse", 1);
        do_rd(4'h0, r); chk("R6 flag set", r, 32'h0000_64A0);
        do_rd(4'h4, r); chk("R6 count wraps", r, 32'd0);

        // R5 refresh restarts count
        ticks(2);
        do_wr(4'h4, 32'hB480_A602);
        ticks(2);
        do_rd(4'h4, r); chk("R5 after refresh", r, 32'd2);
        rst_delta("R5 no reset", 0);

        // R10 flag clear in window
        do_wr(4'h4, 32'hD928_C520);
        do_wr(4'h0, 32'h0000_60A0);
        do_rd(4'h0, r); chk("R10 flag cleared", r, 32'h0000_24A0);
        rst_delta("R10 no reset", 0);

        // R8 bad key and locked write while enabled
        do_wr(4'h4, 32'h0000_0001);
        rst_delta("R8 bad key", 1);
        do_wr(4'h8, 32'd9);
        rst_delta("R8 locked write", 1);
        do_rd(4'h8, r); chk("R3 locked timeout kept", r, 32'd3);

        // R4 window expiry
        do_wr(4'h4, 32'hD928_C520);
        do_rd(4'h0, r); chk("R2 32-bit unlock", r, 32'h0000_28A0);
        repeat (260) @(negedge clk);
        do_rd(4'h0, r); chk("R4 window expired", r, 32'h0000_24A0);
        rst_delta("R4 no reset yet", 0);
        do_wr(4'h8, 32'd9);
        rst_delta("R4 write after expiry", 1);
        do_rd(4'h8, r); chk("R4 timeout kept", r, 32'd3);

        // R7 prescaler
        do_wr(4'h4, 32'hB480_A602);
        do_wr(4'h4, 32'hD928_C520);
        do_wr(4'h0, 32'h0000_30A0);
        ticks(255);
        do_rd(4'h4, r); chk("R7 255 ticks", r, 32'd0);
        ticks(1);
        do_rd(4'h4, r); chk("R7 256 ticks", r, 32'd1);
        rst_delta("R7 no reset", 0);

        // R9 update-allowed cleared; disabled behaviour
        do_wr(4'h4, 32'hB480_A602);
        do_wr(4'h4, 32'hD928_C520);
        do_wr(4'h0, 32'h0000_2000);
        do_rd(4'h0, r); chk("R9 config", r, 32'h0000_2400);
        do_wr(4'h4, 32'hD928_C520);
        do_rd(4'h0, r); chk("R9 unlock rejected", r, 32'h0000_2400);
        do_wr(4'h4, 32'h0000_0001);
        rst_delta("R8 disabled no reset", 0);
        ticks(3);
        do_rd(4'h4, r); chk("R6 disabled holds", r, 32'd0);

        // R2 broken 16-bit pair
        do_reset();
        do_wr(4'h4, 32'h0000_C520);
        do_wr(4'h4, 32'h0000_1234);
        do_rd(4'h0, r); chk("R2 broken pair", r, 32'h0000_0420);
        do_wr(4'h8, 32'd7);
        do_rd(4'h8, r); chk("R3 still locked", r, 32'h0000_0400);

        // R5 16-bit refresh, R8 broken refresh
        do_wr(4'h4, 32'h0000_C520);
        do_wr(4'h4, 32'h0000_D928);
        do_wr(4'h0, 32'h0000_00A0);
        ticks(2);
        do_rd(4'h4, r); chk("R6 16-bit mode count", r, 32'd2);
        do_wr(4'h4, 32'h0000_A602);
        do_wr(4'h4, 32'h0000_B480);
        do_rd(4'h4, r); chk("R5 16-bit refresh", r, 32'd0);
        rst_delta("R5 16-bit no reset", 0);
        do_wr(4'h4, 32'h0000_A602);
        do_wr(4'h4, 32'h0000_0005);
        rst_delta("R8 broken refresh", 1);

        finish_run();
    end
endmodule